// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides an unsigned 2N-bit dividend by an unsigned N-bit divisor. It uses one N+1-bit add/subtract path over N+1 clock cycles. The partial remainder sits in a high register. A sign flag records whether that remainder is negative, and it chooses whether the next step adds or subtracts the divisor. The dividend's lower half sits in a low shift register. As each step shifts this register left, the new quotient bit enters at the bottom, so the same register ends up holding the quotient. After N steps, one correction cycle adds the divisor back if the remainder is negative.

A client drives the operands and pulses `start` while the block is idle. `busy` stays high while the division runs. `done` then rises together with the registered `quotient`, `remainder` and `err`, and all of them hold until the next accepted `start`. The quotient must fit in N bits, which requires the upper half of the dividend to be smaller than the divisor. If the operands break this rule, or the divisor is zero, `err` is raised and the results carry no meaning.

Top module: `serial_divider`

## Requirements
- R1: A `start` sampled high while `busy` is low captures `dividend` and `divisor`, and `busy` is high from the next clock edge on.
- R2: `done` rises and `busy` falls on the (N+1)-th clock edge after the edge that accepted `start`. `done` stays low before that edge.
- R3: When `err` is low at `done`, quotient × divisor + remainder equals the captured dividend.
- R4: When `err` is low at `done`, the remainder is strictly less than the captured divisor.
- R5: A captured divisor of zero makes `err` high from the edge after acceptance until the next accepted `start`.
- R6: `err` is high when the upper N bits of the dividend are greater than or equal to the divisor, and low otherwise.
- R7: A `start` pulse while `busy` is high is ignored. The running division keeps its timing, and its results are those of the operands captured first.
- R8: Once `done` is high, `done`, `err`, `quotient` and `remainder` keep their values until the next accepted `start`, whatever the operand inputs do.
- R9: `busy` and `done` are never high together, and an accepted `start` clears `done` on the next edge.
- R10: After synchronous reset, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division (honoured only when idle) |
| dividend | input | 2N | Unsigned dividend |
| divisor | input | N | Unsigned divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | Results valid, held until next start |
| err | output | 1 | Zero divisor or quotient overflow |
| quotient | output | N | Unsigned quotient |
| remainder | output | N | Unsigned remainder |

## Verification
The hardest case to reach is the pair of extreme operands. In one, the upper dividend half is exactly one below the divisor. In the other, it is exactly equal to the divisor. The first keeps the partial remainder near its full range on every step and takes the add/subtract path through its widest values. The second is the smallest operand pair that breaks the range rule. Random draws almost never hit either value, so directed tasks build them on purpose from an all-ones divisor and from small divisors. A further task pulses `start` mid-division with different operands, which shows that the running operation's timing and results are untouched.

// File: rtl/serial_divider_pkg.sv
package serial_divider_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/serial_divider_step.sv
// One non-restoring iteration: shift the remainder left, bring in a dividend
// bit, then subtract or add the divisor as the sign flag selects.
module serial_divider_step #(
  parameter int N = 16
) (
  input  logic [N-1:0] h_cur,   // partial remainder, low N bits
  input  logic         pos_cur, // 1: remainder non-negative -> subtract
  input  logic         lbit,    // next dividend bit shifted in
  input  logic [N-1:0] dvs,
  output logic [N-1:0] h_nxt,
  output logic         pos_nxt  // also the new quotient bit
);
  logic [N:0] shifted;
  logic [N:0] res;

  // 2R + bit taken modulo 2^(N+1); the true result lies in [-D, D)
  always_comb begin
    shifted = {h_cur, lbit};
    if (pos_cur) res = shifted - {1'b0, dvs};
    else         res = shifted + {1'b0, dvs};
    h_nxt   = res[N-1:0];
    pos_nxt = ~res[N];
  end
endmodule

// File: rtl/serial_divider_ctrl.sv
module serial_divider_ctrl
  import serial_divider_pkg::*;
#(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load_en,
  output logic step_en,
  output logic fix_en,
  output logic busy,
  output logic done
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  div_state_e    st_q;
  logic [CW-1:0] cnt_q;

  assign load_en = (st_q == ST_IDLE) && start;
  assign step_en = (st_q == ST_RUN);
  assign fix_en  = (st_q == ST_FIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q  <= ST_RUN;
          cnt_q <= '0;
          busy  <= 1'b1;
          done  <= 1'b0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= ST_FIX;
        end
        ST_FIX: begin
          st_q <= ST_IDLE;
          busy <= 1'b0;
          done <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R9
  start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> !done);
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  // R2
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

// File: rtl/serial_divider.sv
module serial_divider
  import serial_divider_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2*N-1:0] dividend,
  input  logic [N-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [N-1:0]   quotient,
  output logic [N-1:0]   remainder
);
  logic [N-1:0] h_q, l_q, d_q;
  logic         pos_q;
  logic [N-1:0] h_nxt;
  logic         pos_nxt;
  logic         load_en, step_en, fix_en;

  serial_divider_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load_en(load_en), .step_en(step_en), .fix_en(fix_en),
    .busy(busy), .done(done)
  );

  serial_divider_step #(.N(N)) u_step (
    .h_cur(h_q), .pos_cur(pos_q), .lbit(l_q[N-1]), .dvs(d_q),
    .h_nxt(h_nxt), .pos_nxt(pos_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q   <= '0;
      l_q   <= '0;
      d_q   <= '0;
      pos_q <= 1'b1;
      err   <= 1'b0;
    end else if (load_en) begin
      h_q   <= dividend[2*N-1:N];
      l_q   <= dividend[N-1:0];
      d_q   <= divisor;
      pos_q <= 1'b1;
      err   <= (dividend[2*N-1:N] >= divisor);
    end else if (step_en) begin
      h_q   <= h_nxt;
      pos_q <= pos_nxt;
      l_q   <= {l_q[N-2:0], pos_nxt};
    end else if (fix_en) begin
      if (!pos_q) h_q <= h_q + d_q;
      pos_q <= 1'b1;
    end
  end

  assign quotient  = l_q;
  assign remainder = h_q;

  // R4
  rem_below_div_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (remainder < d_q));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(err)));
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(d_q));
  // R5
  zero_div_err_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=> err);
endmodule

// File: tb/serial_divider_test.sv
module serial_divider_test;
  localparam int N = 16;

  logic           clk = 1'b0;
  logic           rst;
  logic           start;
  logic [2*N-1:0] dividend;
  logic [N-1:0]   divisor;
  logic           busy, done, err;
  logic [N-1:0]   quotient, remainder;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  serial_divider #(.N(N)) uut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .err(err),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Issue one division and check timing, flag and arithmetic.
  task automatic run_op(input logic [2*N-1:0] a, input logic [N-1:0] b,
                        input bit exp_err, input string errtag);
    longint q, r;
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after accept", longint'(busy), 1);
    chk("R9 done cleared by start", longint'(done), 0);
    repeat (N) @(negedge clk);
    chk("R2 done low before N+1 edges", longint'(done), 0);
    @(negedge clk);
    chk("R2 done at edge N+1", longint'(done), 1);
    chk("R2 busy low at done", longint'(busy), 0);
    chk(errtag, longint'(err), longint'(exp_err));
    if (!exp_err) begin
      q = longint'(quotient); r = longint'(remainder);
      chk("R3 q*d+r==dividend", q * longint'(b) + r, longint'(a));
      chk("R4 remainder<divisor", longint'(r < longint'(b)), 1);
    end
  endtask

  task automatic t_reset();
    chk("R10 busy after reset", longint'(busy), 0);
    chk("R10 done after reset", longint'(done), 0);
    chk("R10 err after reset", longint'(err), 0);
  endtask

  task automatic t_edges();
    logic [N-1:0] ones = '1;
    run_op({ones - 1'b1, ones}, ones, 1'b0, "R6 max valid no err");
    run_op('0, 16'd1, 1'b0, "R6 zero dividend no err");
    run_op({16'd0, ones}, 16'd1, 1'b0, "R6 divisor one no err");
    run_op({16'd0, 16'd5}, 16'd7, 1'b0, "R6 small no err");
    run_op({16'd255, 16'h1234}, 16'd256, 1'b0, "R6 pow2 no err");
    run_op({16'd2, 16'hFFFF}, 16'd3, 1'b0, "R6 hi=d-1 no err");
  endtask

  task automatic t_errors();
    run_op({16'd0, 16'd9}, 16'd0, 1'b1, "R5 zero divisor err");
    run_op({16'd3, 16'd0}, 16'd3, 1'b1, "R6 hi==divisor err");
    run_op({16'hFFFF, 16'hFFFF}, 16'd100, 1'b1, "R6 hi>divisor err");
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic [N-1:0] b, hi, lo;
      b  = N'($urandom);
      if (b == '0) b = 1;
      hi = N'($urandom % b);
      lo = N'($urandom);
      run_op({hi, lo}, b, 1'b0, "R6 random no err");
    end
  endtask

  task automatic t_busy_start();
    @(negedge clk);
    dividend = {16'd10, 16'd77}; divisor = 16'd13; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    dividend = {16'd1, 16'd1}; divisor = 16'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (N - 4) @(negedge clk);
    chk("R7 done not early", longint'(done), 0);
    @(negedge clk);
    chk("R7 done on original schedule", longint'(done), 1);
    chk("R7 quotient of first op", longint'(quotient), (10 * 65536 + 77) / 13);
    chk("R7 remainder of first op", longint'(remainder), (10 * 65536 + 77) % 13);
  endtask

  task automatic t_hold();
    logic [N-1:0] q0, r0;
    run_op({16'd40, 16'd900}, 16'd77, 1'b0, "R6 hold op no err");
    q0 = quotient; r0 = remainder;
    dividend = '1; divisor = '0;
    repeat (6) @(negedge clk);
    chk("R8 done held", longint'(done), 1);
    chk("R8 quotient held", longint'(quotient), longint'(q0));
    chk("R8 remainder held", longint'(remainder), longint'(r0));
    chk("R8 err held", longint'(err), 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst = 1'b1; start = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_edges();
    t_errors();
    t_busy_start();
    t_hold();
    t_random();
    finish_run();
  end
endmodule